// File: doc/BRIEF.md
# DDR SDRAM Command Rule Monitor

This block watches the command bus of one rank of a four-bank double data rate SDRAM from the controller side. On every rising clock edge it samples chip select, the three active-low strobes that encode the command, the two bank bits and the address bus. It decodes bank activation, read, write, precharge, auto refresh and mode register load. For every bank it keeps a record of whether a row is open, and which row.

Each minimum command spacing is given in picoseconds and turned into a whole number of clocks when the design is elaborated, by rounding up against the clock period. The write-to-activate delay after a write with auto-precharge is built from the write recovery and the precharge period. Each of these two terms is rounded up on its own before they are added.

When a command breaks a state rule or a spacing rule, the block raises a one-cycle error pulse with a one-hot code. A command that is flagged is dropped: it has no effect on the tracked state. The block is a passive observer. It drives nothing back onto the memory bus.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: Commands are taken only at the rising clock edge with cs_n low. The strobes {ras_n,cas_n,we_n} encode the command: 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh, 000 mode register load. The codes 111 and 110 are ignored entirely.
- R2: While cs_n is high the sampled command is ignored and raises no error. Spacing counters keep running during those cycles.
- R3: An accepted activate marks its bank open. It also stores the full address bus as that bank's row in open_row, at bits [b*ADDR_W +: ADDR_W] for bank b.
- R4: A read or write to a bank that is not open gives error code 3'b001 and changes no state.
- R5: Three commands give error code 3'b010: an activate to a bank that is already open, and an auto refresh or mode register load issued while any bank is open.
- R6: A read or write with addr[10] high closes the addressed bank. The next activate to that bank must then wait burst+tRP clocks after a read, or burst+tDAL clocks after a write. With addr[10] low the bank stays open.
- R7: A precharge with addr[10] high closes every open bank, whatever the bank bits are. With addr[10] low it closes only the addressed bank. A precharge to an idle bank is legal and has no effect.
- R8: Spacing violations give error code 3'b100. At the default period of 7000 ps, the limits in clocks are: activate to read/write in the same bank 3, activate to precharge 6, precharge to activate or refresh 3, activate to activate in the same bank 9, and activate to activate in any bank 2.
- R9: A precharge must come at least burst+ceil(tWR/tCK) clocks after a write to the same bank, which is 7 by default. After a write with auto-precharge, an activate to that bank must wait burst+ceil(tWR/tCK)+ceil(tRP/tCK) clocks, which is 4+3+3=10 by default.
- R10: A read must come at least burst+1 = 5 clocks after any write. After a mode register load, any command must wait 2 clocks.
- R11: err_valid is high for exactly the one cycle after a flagged command, and err_code is one-hot while err_valid is high and zero otherwise. When a command breaks both a state rule and a spacing rule, only the state code is reported.
- R12: Reset closes all banks, clears all rows to zero, clears the error outputs and clears every spacing counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | ADDR_W (13) | Row address, or column address with auto-precharge/all-bank flag on bit 10 |
| err_valid | output | 1 | One-cycle pulse when a rule is broken |
| err_code | output | 3 | One-hot: bit0 idle-bank access, bit1 open-bank conflict, bit2 spacing |
| bank_open | output | 4 | One bit per bank, high while a row is open |
| open_row | output | 4*ADDR_W | Row last activated in each bank |

## Verification
A single command can break a state rule and a spacing rule at once. For example, a second activate to a bank issued one clock after the first hits both the open-bank rule and the activate-to-activate spacing. The bench provokes this on purpose and expects only the open-bank code. A separate case checks that precharge-all to an idle bank number still closes every other bank. Fixed-seed random traffic exercises the remaining overlaps: deselects, auto-precharge closes and recovery windows. It is judged against a timestamp model that records, per bank, the earliest clock at which each command becomes legal.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

    localparam int BA_W  = 2;
    localparam int NB    = 1 << BA_W;
    localparam int ERR_W = 3;

    localparam logic [ERR_W-1:0] E_NONE = 3'b000;
    localparam logic [ERR_W-1:0] E_IDLE = 3'b001;
    localparam logic [ERR_W-1:0] E_OPEN = 3'b010;
    localparam logic [ERR_W-1:0] E_TIME = 3'b100;

    typedef enum logic [2:0] {
        OP_NONE, OP_ACT, OP_RD, OP_WR, OP_PRE, OP_REF, OP_MRS
    } op_e;

    typedef struct packed {
        op_e             op;
        logic [BA_W-1:0] bank;
        logic            ap;
    } cmd_t;

    // whole clocks covering a span given in picoseconds
    function automatic int ps_to_cyc(int span_ps, int clk_ps);
        return (span_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // countdown step: decrement, or raise to n-1 when a new window opens
    function automatic int stretch(int cur, logic ld, int n);
        int d;
        d = (cur > 0) ? cur - 1 : 0;
        if (ld && (n - 1) > d) d = n - 1;
        return d;
    endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_mon_pkg::*;
(
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            ap,
    output cmd_t            cmd
);
    always_comb begin
        cmd.bank = ba;
        cmd.ap   = ap;
        cmd.op   = OP_NONE;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd.op = OP_ACT;
                3'b101:  cmd.op = OP_RD;
                3'b100:  cmd.op = OP_WR;
                3'b010:  cmd.op = OP_PRE;
                3'b001:  cmd.op = OP_REF;
                3'b000:  cmd.op = OP_MRS;
                default: cmd.op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ddr_bank_state.sv
module ddr_bank_state
    import ddr_mon_pkg::*;
#(
    parameter int BANK_ID  = 0,
    parameter int ROW_W    = 13,
    parameter int CW       = 4,
    parameter int N_RCD    = 3,
    parameter int N_RAS    = 6,
    parameter int N_RC     = 9,
    parameter int N_RP     = 3,
    parameter int N_RD_AP  = 7,
    parameter int N_WR_AP  = 10,
    parameter int N_WR_PRE = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             take_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             rw_ok_o,
    output logic             pre_ok_o,
    output logic             act_ok_o,
    output logic             rest_ok_o
);
    logic [CW-1:0] rcd_q, ras_q, rc_q, prea_q, wrp_q;
    logic [CW-1:0] rcd_d, ras_d, rc_d, prea_d, wrp_d;
    logic          open_d;
    logic          hit, ld_act, ld_wr, ld_pre, ld_rdap, ld_wrap;

    assign hit     = (cmd_i.bank == BA_W'(BANK_ID));
    assign ld_act  = take_i && hit && (cmd_i.op == OP_ACT);
    assign ld_wr   = take_i && hit && (cmd_i.op == OP_WR);
    assign ld_rdap = take_i && hit && (cmd_i.op == OP_RD) && cmd_i.ap;
    assign ld_wrap = ld_wr && cmd_i.ap;
    assign ld_pre  = take_i && open_o && (cmd_i.op == OP_PRE) && (cmd_i.ap || hit);

    always_comb begin
        int p;
        rcd_d = CW'(stretch(int'(rcd_q), ld_act, N_RCD));
        ras_d = CW'(stretch(int'(ras_q), ld_act, N_RAS));
        rc_d  = CW'(stretch(int'(rc_q),  ld_act, N_RC));
        wrp_d = CW'(stretch(int'(wrp_q), ld_wr,  N_WR_PRE));
        p = stretch(int'(prea_q), ld_pre, N_RP);
        p = imax(p, stretch(int'(prea_q), ld_rdap, N_RD_AP));
        p = imax(p, stretch(int'(prea_q), ld_wrap, N_WR_AP));
        prea_d = CW'(p);
        open_d = open_o;
        if (ld_act) open_d = 1'b1;
        if (ld_rdap || ld_wrap || ld_pre) open_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rcd_q  <= '0;
            ras_q  <= '0;
            rc_q   <= '0;
            prea_q <= '0;
            wrp_q  <= '0;
            open_o <= 1'b0;
            row_o  <= '0;
        end else begin
            rcd_q  <= rcd_d;
            ras_q  <= ras_d;
            rc_q   <= rc_d;
            prea_q <= prea_d;
            wrp_q  <= wrp_d;
            open_o <= open_d;
            if (ld_act) row_o <= row_i;
        end
    end

    assign rw_ok_o   = (rcd_q == '0);
    assign pre_ok_o  = (ras_q == '0) && (wrp_q == '0);
    assign act_ok_o  = (rc_q == '0) && (prea_q == '0);
    assign rest_ok_o = (prea_q == '0);
endmodule

// File: rtl/ddr_rule_engine.sv
module ddr_rule_engine
    import ddr_mon_pkg::*;
#(
    parameter int CW    = 4,
    parameter int N_RRD = 2,
    parameter int N_WTR = 5,
    parameter int N_MRD = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd_i,
    input  logic [NB-1:0]    open_v,
    input  logic [NB-1:0]    rw_ok_v,
    input  logic [NB-1:0]    pre_ok_v,
    input  logic [NB-1:0]    act_ok_v,
    input  logic [NB-1:0]    rest_ok_v,
    output logic             take_o,
    output logic             err_valid,
    output logic [ERR_W-1:0] err_code
);
    logic [CW-1:0]    rrd_q, wtr_q, mrd_q;
    logic [ERR_W-1:0] st_err, code;
    logic             late;
    logic [NB-1:0]    pre_tgt;

    always_comb begin
        pre_tgt = cmd_i.ap ? open_v : (open_v & (NB'(1) << cmd_i.bank));
        st_err  = E_NONE;
        late    = 1'b0;
        case (cmd_i.op)
            OP_ACT: begin
                if (open_v[cmd_i.bank]) st_err = E_OPEN;
                late = !act_ok_v[cmd_i.bank] || (rrd_q != '0);
            end
            OP_RD: begin
                if (!open_v[cmd_i.bank]) st_err = E_IDLE;
                late = !rw_ok_v[cmd_i.bank] || (wtr_q != '0);
            end
            OP_WR: begin
                if (!open_v[cmd_i.bank]) st_err = E_IDLE;
                late = !rw_ok_v[cmd_i.bank];
            end
            OP_PRE: late = |(pre_tgt & ~pre_ok_v);
            OP_REF, OP_MRS: begin
                if (|open_v) st_err = E_OPEN;
                late = !(&rest_ok_v);
            end
            default: late = 1'b0;
        endcase
        if (cmd_i.op != OP_NONE && mrd_q != '0) late = 1'b1;
        if (st_err != E_NONE) code = st_err;
        else if (late)        code = E_TIME;
        else                  code = E_NONE;
        take_o = (cmd_i.op != OP_NONE) && (code == E_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            err_code  <= E_NONE;
            rrd_q     <= '0;
            wtr_q     <= '0;
            mrd_q     <= '0;
        end else begin
            err_valid <= (code != E_NONE);
            err_code  <= code;
            rrd_q <= CW'(stretch(int'(rrd_q), take_o && cmd_i.op == OP_ACT, N_RRD));
            wtr_q <= CW'(stretch(int'(wtr_q), take_o && cmd_i.op == OP_WR,  N_WTR));
            mrd_q <= CW'(stretch(int'(mrd_q), take_o && cmd_i.op == OP_MRS, N_MRD));
        end
    end
endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
    import ddr_mon_pkg::*;
#(
    parameter int CLK_PS    = 7000,
    parameter int T_RCD_PS  = 18000,
    parameter int T_RAS_PS  = 42000,
    parameter int T_RP_PS   = 18000,
    parameter int T_RC_PS   = 60000,
    parameter int T_RRD_PS  = 12000,
    parameter int T_WR_PS   = 15000,
    parameter int BURST_CYC = 4,
    parameter int WTR_CYC   = 1,
    parameter int MRD_CYC   = 2,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 err_valid,
    output logic [ERR_W-1:0]     err_code,
    output logic [NB-1:0]        bank_open,
    output logic [NB*ADDR_W-1:0] open_row
);
    localparam int N_RCD    = ps_to_cyc(T_RCD_PS, CLK_PS);
    localparam int N_RAS    = ps_to_cyc(T_RAS_PS, CLK_PS);
    localparam int N_RP     = ps_to_cyc(T_RP_PS,  CLK_PS);
    localparam int N_RC     = ps_to_cyc(T_RC_PS,  CLK_PS);
    localparam int N_RRD    = ps_to_cyc(T_RRD_PS, CLK_PS);
    localparam int N_WR     = ps_to_cyc(T_WR_PS,  CLK_PS);
    localparam int N_DAL    = N_WR + N_RP;
    localparam int N_RD_AP  = BURST_CYC + N_RP;
    localparam int N_WR_AP  = BURST_CYC + N_DAL;
    localparam int N_WR_PRE = BURST_CYC + N_WR;
    localparam int N_WTR    = BURST_CYC + WTR_CYC;
    localparam int MAXC     = imax(imax(imax(N_RC, N_WR_AP), imax(N_RD_AP, N_RAS)),
                                   imax(imax(N_WR_PRE, N_WTR), imax(MRD_CYC, N_RRD)));
    localparam int CW       = $clog2(MAXC + 1);

    cmd_t          cmd;
    logic          take;
    logic [NB-1:0] rw_ok, pre_ok, act_ok, rest_ok;

    ddr_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .ap(addr[AP_BIT]), .cmd(cmd)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        ddr_bank_state #(
            .BANK_ID(b), .ROW_W(ADDR_W), .CW(CW),
            .N_RCD(N_RCD), .N_RAS(N_RAS), .N_RC(N_RC), .N_RP(N_RP),
            .N_RD_AP(N_RD_AP), .N_WR_AP(N_WR_AP), .N_WR_PRE(N_WR_PRE)
        ) u_bank (
            .clk(clk), .rst(rst), .cmd_i(cmd), .row_i(addr), .take_i(take),
            .open_o(bank_open[b]), .row_o(open_row[b*ADDR_W +: ADDR_W]),
            .rw_ok_o(rw_ok[b]), .pre_ok_o(pre_ok[b]),
            .act_ok_o(act_ok[b]), .rest_ok_o(rest_ok[b])
        );
    end

    ddr_rule_engine #(
        .CW(CW), .N_RRD(N_RRD), .N_WTR(N_WTR), .N_MRD(MRD_CYC)
    ) u_rules (
        .clk(clk), .rst(rst), .cmd_i(cmd),
        .open_v(bank_open), .rw_ok_v(rw_ok), .pre_ok_v(pre_ok),
        .act_ok_v(act_ok), .rest_ok_v(rest_ok),
        .take_o(take), .err_valid(err_valid), .err_code(err_code)
    );
endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk
    import ddr_mon_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [BA_W-1:0]  ba,
    input logic             ap,
    input logic             err_valid,
    input logic [ERR_W-1:0] err_code,
    input logic [NB-1:0]    bank_open
);
    logic is_act, is_rw, is_pre_all;
    assign is_act     = !cs_n && !ras_n && cas_n && we_n;
    assign is_rw      = !cs_n && ras_n && !cas_n;
    assign is_pre_all = !cs_n && !ras_n && cas_n && !we_n && ap;

    AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> ($countones(err_code) == 1)); // R11
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !err_valid |-> (err_code == '0)); // R11
    AST_DESELECT_SILENT: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !err_valid); // R2
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        is_act |=> (err_valid || bank_open[$past(ba)])); // R3
    AST_IDLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (is_rw && !bank_open[ba]) |=> (err_valid && err_code[0])); // R4
    AST_AP_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (is_rw && ap) |=> (err_valid || !bank_open[$past(ba)])); // R6
    AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (rst)
        is_pre_all |=> (err_valid || bank_open == '0)); // R7
endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .ap(addr[AP_BIT]), .err_valid(err_valid),
    .err_code(err_code), .bank_open(bank_open)
);

// File: tb/ddr_cmd_monitor_test.sv
module ddr_cmd_monitor_test;
    localparam int AW = 13;
    localparam int CLKP = 7000;
    function automatic int cdiv(int a, int b); return (a + b - 1) / b; endfunction
    localparam int K_RCD = cdiv(18000, CLKP);
    localparam int K_RAS = cdiv(42000, CLKP);
    localparam int K_RP  = cdiv(18000, CLKP);
    localparam int K_RC  = cdiv(60000, CLKP);
    localparam int K_RRD = cdiv(12000, CLKP);
    localparam int K_WR  = cdiv(15000, CLKP);
    localparam int BL    = 4;
    localparam int K_DAL = K_WR + K_RP;

    // bench operation numbers
    localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, REF = 5, MRS = 6, BST = 7;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [AW-1:0] addr = '0;
    logic err_valid;
    logic [2:0] err_code;
    logic [3:0] bank_open;
    logic [4*AW-1:0] open_row;

    always #10 clk = ~clk;

    ddr_cmd_monitor uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .err_valid(err_valid), .err_code(err_code),
        .bank_open(bank_open), .open_row(open_row)
    );

    int n_chk = 0, n_bad = 0, t = 0, last_code = 0;
    bit done = 0;
    bit mopen [4];
    logic [AW-1:0] mrow [4];
    int rw_ok [4], pre_ok [4], prea_ok [4], rc_ok [4];
    int rrd_ok, wtr_ok, mrd_ok;

    function automatic int mx(int a, int b); return a > b ? a : b; endfunction

    function automatic logic [2:0] enc(int op);
        case (op)
            ACT: return 3'b011;  RD:  return 3'b101;  WR:  return 3'b100;
            PRE: return 3'b010;  REF: return 3'b001;  MRS: return 3'b000;
            BST: return 3'b110;  default: return 3'b111;
        endcase
    endfunction

    task automatic model_reset();
        t = 0; rrd_ok = 0; wtr_ok = 0; mrd_ok = 0;
        for (int i = 0; i < 4; i++) begin
            mopen[i] = 0; mrow[i] = '0;
            rw_ok[i] = 0; pre_ok[i] = 0; prea_ok[i] = 0; rc_ok[i] = 0;
        end
    endtask

    function automatic int exp_code(int op, int b, bit a10, bit desel);
        int st = 0; bit tm = 0;
        if (desel || op == NOP || op == BST) return 0;
        case (op)
            ACT: begin if (mopen[b]) st = 2;
                       tm = (t < rc_ok[b]) || (t < prea_ok[b]) || (t < rrd_ok); end
            RD:  begin if (!mopen[b]) st = 1; tm = (t < rw_ok[b]) || (t < wtr_ok); end
            WR:  begin if (!mopen[b]) st = 1; tm = (t < rw_ok[b]); end
            PRE: for (int i = 0; i < 4; i++)
                     if (mopen[i] && (a10 || i == b) && t < pre_ok[i]) tm = 1;
            default: for (int i = 0; i < 4; i++) begin
                         if (mopen[i]) st = 2;
                         if (t < prea_ok[i]) tm = 1;
                     end
        endcase
        if (t < mrd_ok) tm = 1;
        if (st != 0) return st;
        return tm ? 4 : 0;
    endfunction

    task automatic model_apply(int op, int b, bit a10, logic [AW-1:0] row);
        case (op)
            ACT: begin mopen[b] = 1; mrow[b] = row; rw_ok[b] = t + K_RCD;
                       pre_ok[b] = mx(pre_ok[b], t + K_RAS); rc_ok[b] = t + K_RC;
                       rrd_ok = t + K_RRD; end
            RD:  if (a10) begin mopen[b] = 0; prea_ok[b] = mx(prea_ok[b], t + BL + K_RP); end
            WR:  begin wtr_ok = t + BL + 1; pre_ok[b] = mx(pre_ok[b], t + BL + K_WR);
                       if (a10) begin mopen[b] = 0; prea_ok[b] = mx(prea_ok[b], t + BL + K_DAL); end end
            PRE: for (int i = 0; i < 4; i++)
                     if (mopen[i] && (a10 || i == b)) begin
                         mopen[i] = 0; prea_ok[i] = mx(prea_ok[i], t + K_RP);
                     end
            MRS: mrd_ok = t + 2;
            default: ;
        endcase
    endtask

    task automatic check(bit ok, string tag, string what, int act_v, int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act_v, exp_v);
        end
    endtask

    task automatic step(int op, int b, bit a10, logic [AW-1:0] row, bit desel, string tag);
        int e;
        logic [3:0] mo;
        cs_n = desel;
        {ras_n, cas_n, we_n} = enc(op);
        ba = 2'(b);
        addr = row;
        if (op != ACT) addr[10] = a10;
        e = exp_code(op, b, a10, desel);
        @(negedge clk);
        last_code = int'(err_code);
        check(err_valid == (e != 0) && int'(err_code) == e, tag, "error code", int'(err_code), e);
        if (e == 0 && !desel) model_apply(op, b, a10, (op == ACT) ? addr : row);
        for (int i = 0; i < 4; i++) mo[i] = mopen[i];
        check(bank_open == mo, tag, "bank_open", int'(bank_open), int'(mo));
        for (int i = 0; i < 4; i++)
            check(open_row[i*AW +: AW] == mrow[i], tag, "open_row",
                  int'(open_row[i*AW +: AW]), int'(mrow[i]));
        t++;
    endtask

    task automatic nops(int n);
        for (int i = 0; i < n; i++) step(NOP, 0, 0, '0, 0, "R1");
    endtask

    task automatic lit(int e, string tag);
        check(last_code == e, tag, "directed code", last_code, e);
    endtask

    task automatic do_reset();
        rst = 1; cs_n = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        model_reset();
        check(err_valid == 0 && err_code == 0, "R12", "reset error", int'(err_code), 0);
        check(bank_open == 0 && open_row == '0, "R12", "reset banks", int'(bank_open), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R8 spacing after activate and precharge
        step(ACT, 0, 0, 13'h1ABC, 0, "R3");  lit(0, "R3");
        nops(1);
        step(RD, 0, 0, 13'h010, 0, "R8");    lit(4, "R8");
        step(RD, 0, 0, 13'h010, 0, "R8");    lit(0, "R8");
        step(PRE, 0, 0, '0, 0, "R8");        lit(4, "R8");
        nops(1);
        step(PRE, 0, 0, '0, 0, "R8");        lit(0, "R8");
        step(ACT, 0, 0, 13'h0055, 0, "R8");  lit(4, "R8");
        nops(1);
        step(ACT, 0, 0, 13'h0055, 0, "R8");  lit(0, "R8");
        step(ACT, 1, 0, 13'h0777, 0, "R8");  lit(4, "R8");
        step(ACT, 1, 0, 13'h0777, 0, "R8");  lit(0, "R8");
        // R5/R11 open conflict together with spacing breach
        step(ACT, 1, 0, 13'h0888, 0, "R11"); lit(2, "R11");
        // R4 idle access
        step(RD, 2, 0, '0, 0, "R4");         lit(1, "R4");
        step(WR, 3, 0, '0, 0, "R4");         lit(1, "R4");
        // R2 deselect ignored
        step(ACT, 2, 0, 13'h0333, 1, "R2");  lit(0, "R2");
        check(bank_open[2] == 0, "R2", "deselected bank", int'(bank_open[2]), 0);
        // R9 write with auto-precharge, separately rounded terms
        nops(2);
        step(ACT, 2, 0, 13'h0222, 0, "R3");  lit(0, "R3");
        nops(2);
        step(WR, 2, 1, '0, 0, "R6");         lit(0, "R6");
        check(bank_open[2] == 0, "R6", "auto-precharge close", int'(bank_open[2]), 0);
        nops(8);
        step(ACT, 2, 0, 13'h0444, 0, "R9");  lit(4, "R9");
        step(ACT, 2, 0, 13'h0444, 0, "R9");  lit(0, "R9");
        // R9 write recovery before precharge
        nops(1);
        step(ACT, 3, 0, 13'h0999, 0, "R3");  lit(0, "R3");
        nops(2);
        step(WR, 3, 0, '0, 0, "R9");         lit(0, "R9");
        nops(5);
        step(PRE, 3, 0, '0, 0, "R9");        lit(4, "R9");
        step(PRE, 3, 0, '0, 0, "R9");        lit(0, "R9");
        // R10 write to read
        step(WR, 2, 0, '0, 0, "R10");        lit(0, "R10");
        nops(3);
        step(RD, 2, 0, '0, 0, "R10");        lit(4, "R10");
        step(RD, 2, 0, '0, 0, "R10");        lit(0, "R10");
        // R6 read with auto-precharge then access
        step(RD, 2, 1, '0, 0, "R6");         lit(0, "R6");
        step(RD, 2, 0, '0, 0, "R6");         lit(1, "R6");
        // R5 refresh with banks open
        step(REF, 0, 0, '0, 0, "R5");        lit(2, "R5");
        // R7 precharge-all with idle bank number, then R8 refresh spacing
        nops(4);
        step(PRE, 3, 1, '0, 0, "R7");        lit(0, "R7");
        check(bank_open == 0, "R7", "all closed", int'(bank_open), 0);
        step(PRE, 1, 0, '0, 0, "R7");        lit(0, "R7");
        step(REF, 0, 0, '0, 0, "R8");        lit(4, "R8");
        nops(1);
        step(REF, 0, 0, '0, 0, "R8");        lit(0, "R8");
        // R10 mode register spacing
        step(MRS, 0, 0, '0, 0, "R10");       lit(0, "R10");
        step(ACT, 0, 0, 13'h0100, 0, "R10"); lit(4, "R10");
        step(ACT, 0, 0, 13'h0100, 0, "R10"); lit(0, "R10");
        // R7 single-bank precharge leaves the other bank open
        nops(2);
        step(ACT, 1, 0, 13'h0101, 0, "R3");  lit(0, "R3");
        nops(6);
        step(PRE, 0, 0, '0, 0, "R7");        lit(0, "R7");
        check(bank_open == 4'b0010, "R7", "single close", int'(bank_open), 2);
        // R1 ignored codes
        step(BST, 1, 0, '0, 0, "R1");        lit(0, "R1");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int op, b; bit a10, ds; string tg;
            op = int'($urandom % 8);
            b  = int'($urandom % 4);
            a10 = ($urandom % 4) == 0;
            ds  = ($urandom % 8) == 0;
            case (op)
                ACT: tg = "R8"; RD, WR: tg = "R6"; PRE: tg = "R7";
                REF, MRS: tg = "R5"; default: tg = "R1";
            endcase
            if (ds) tg = "R2";
            step(op, b, a10, AW'($urandom), ds, tg);
        end

        // R12 reset mid-run clears counters
        step(ACT, 0, 0, 13'h0123, 0, "R12");
        do_reset();
        step(ACT, 0, 0, 13'h0456, 0, "R12"); lit(0, "R12");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule